// File: doc/BRIEF.md
# Byte-Accessed Reloadable Down Counter

This block is a 16-bit down counter that sits on an 8-bit register bus. The upper and lower byte addresses are shared by two registers. A read returns the live count. A write goes to the reload register. A software start request, accepted only while the count-enable input is high, copies the reload value into the counter and arms counting. From then on, each count-clock pulse decrements the counter by one. A pulse seen at zero reloads the counter and raises a one-cycle underflow flag.

An 8-bit bus cannot read a running 16-bit value in one access. Reading the upper byte therefore also captures the lower byte in a holding register, and the next lower-byte read returns that captured value. This gives a consistent 16-bit value across two byte reads. A separate word-wide path reads the live count and writes the whole reload value in one cycle, without going through the holding register.

Top module: `byte_reload_timer`

## Requirements
- R1: After reset the counter, the reload register and the lower-byte holding register are all 0, and `underflow_o` is 0.
- R2: A `start_i` pulse while `cnt_en_i` is 1 loads the reload value into the counter on that clock edge and arms counting.
- R3: A `start_i` pulse while `cnt_en_i` is 0 is ignored: the counter keeps its value and no reload happens.
- R4: When counting is armed and `cnt_en_i` is 1, a `tick_i` pulse with a nonzero count decrements the counter by exactly 1.
- R5: A `tick_i` pulse while the armed counter is 0x0000 reloads the counter from the reload register and drives `underflow_o` high for the following cycle only.
- R6: A byte read with `addr_hi_i`=1 returns count bits 15:8 on `rdata_o` in the same cycle and captures count bits 7:0 into the holding register.
- R7: A byte read with `addr_hi_i`=0 returns the holding register, not the live low byte, so that byte stays paired with the preceding upper-byte read while the counter runs.
- R8: A byte write with `addr_hi_i`=1 updates reload bits 15:8, and one with `addr_hi_i`=0 updates reload bits 7:0. Neither write changes the counter or the other reload byte.
- R9: `word_we_i` writes all 16 reload bits in one cycle. `word_rdata_o` always shows the live count.
- R10: A lower-byte read with no upper-byte read before it returns the last captured value (0 after reset).
- R11: While counting is not armed, or while `cnt_en_i` is 0, `tick_i` leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count-enable control bit |
| start_i | input | 1 | Start request pulse |
| tick_i | input | 1 | Count-clock enable pulse |
| re_i | input | 1 | Byte read strobe |
| we_i | input | 1 | Byte write strobe |
| addr_hi_i | input | 1 | Byte select: 1 upper, 0 lower |
| wdata_i | input | 8 | Byte write data |
| rdata_o | output | 8 | Byte read data (0 when no read) |
| word_we_i | input | 1 | Word-wide reload write strobe |
| word_wdata_i | input | 16 | Word-wide reload write data |
| word_rdata_o | output | 16 | Live 16-bit count |
| underflow_o | output | 1 | One-cycle pulse after the counter passes zero |

## Verification
The in-line assertions check these relations on every clock: a start with enable loads the reload value, a start without enable leaves the count untouched, a tick decrements by one, an underflow pulse follows only a tick at zero, the holding register changes only on an upper-byte read, and a lower-byte write leaves the upper reload byte alone. Some behaviours need a sequence of accesses, and only the directed scenarios show them. These are the pairing of an upper-byte read with a later lower-byte read while ticks change the live count, a repeated lower-byte read returning the stale captured value, and a byte write not disturbing the counter until the next start.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = CNT_W / BYTE_W;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/reload_store.sv
module reload_store
  import reload_timer_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          addr_hi_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          word_we_i,
  input  logic [W-1:0]  word_wdata_i,
  output logic [W-1:0]  reload_o
);
  localparam int unsigned NB = W / BW;

  logic [W-1:0] reload_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic IS_HI = (b == NB - 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reload_q[b*BW +: BW] <= '0;
      end else if (word_we_i) begin
        reload_q[b*BW +: BW] <= word_wdata_i[b*BW +: BW];
      end else if (we_i && (addr_hi_i == IS_HI)) begin
        reload_q[b*BW +: BW] <= wdata_i;
      end
    end
  end

  assign reload_o = reload_q;

  // R8
  lo_write_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_hi_i && !word_we_i) |=> $stable(reload_q[W-1 -: BW]));
endmodule

// File: rtl/down_count_core.sv
module down_count_core
  import reload_timer_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         start_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         underflow_o
);
  logic [W-1:0] count_q;
  logic         armed_q;
  logic         uf_q;
  logic         step;

  assign step = cnt_en_i && armed_q && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      armed_q <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      if (!cnt_en_i) begin
        armed_q <= 1'b0;
      end else if (start_i) begin
        armed_q <= 1'b1;
        count_q <= reload_i;
      end else if (step) begin
        if (count_q == '0) begin
          count_q <= reload_i;
          uf_q    <= 1'b1;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  assign count_o     = count_q;
  assign underflow_o = uf_q;

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cnt_en_i) |=> (count_q == $past(reload_i)));
  // R3
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cnt_en_i) |=> $stable(count_q));
  // R4
  decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !start_i && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
  // R5
  underflow_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uf_q) |-> ($past(count_q) == '0 && $past(tick_i)));
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !step) |=> $stable(count_q));
endmodule

// File: rtl/byte_read_port.sv
module byte_read_port
  import reload_timer_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic          addr_hi_i,
  input  logic [W-1:0]  count_i,
  output logic [BW-1:0] rdata_o
);
  logic [BW-1:0] hold_q;
  logic          rd_hi;

  assign rd_hi = re_i && (byte_sel_e'(addr_hi_i) == SEL_HI);

  // capture low byte together with the upper-byte read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (rd_hi) hold_q <= count_i[BW-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) rdata_o = rd_hi ? count_i[W-1 -: BW] : hold_q;
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hi |=> $stable(hold_q));
  // R6
  hold_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi |=> (hold_q == $past(count_i[BW-1:0])));
endmodule

// File: rtl/byte_reload_timer.sv
module byte_reload_timer
  import reload_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic              addr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              word_we_i,
  input  logic [CNT_W-1:0]  word_wdata_i,
  output logic [CNT_W-1:0]  word_rdata_o,
  output logic              underflow_o
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;

  reload_store #(.W(CNT_W), .BW(BYTE_W)) u_reload (
    .clk_i, .rst_ni, .we_i, .addr_hi_i, .wdata_i,
    .word_we_i, .word_wdata_i, .reload_o(reload)
  );

  down_count_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni, .cnt_en_i, .start_i, .tick_i,
    .reload_i(reload), .count_o(count), .underflow_o
  );

  byte_read_port #(.W(CNT_W), .BW(BYTE_W)) u_rd (
    .clk_i, .rst_ni, .re_i, .addr_hi_i, .count_i(count), .rdata_o
  );

  assign word_rdata_o = count;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (word_rdata_o == '0 && !underflow_o));
endmodule

// File: tb/byte_reload_timer_tb_top.sv
module byte_reload_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, start = 1'b0, tick = 1'b0;
  logic        re = 1'b0, we = 1'b0, addr_hi = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        word_we = 1'b0;
  logic [15:0] word_wdata = '0;
  logic [15:0] word_rdata;
  logic        uf;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_reload_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .start_i(start), .tick_i(tick),
    .re_i(re), .we_i(we), .addr_hi_i(addr_hi), .wdata_i(wdata), .rdata_o(rdata),
    .word_we_i(word_we), .word_wdata_i(word_wdata), .word_rdata_o(word_rdata),
    .underflow_o(uf)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic byte_wr(logic hi, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr_hi = hi; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic word_wr(logic [15:0] d);
    @(negedge clk); word_we = 1'b1; word_wdata = d;
    @(negedge clk); word_we = 1'b0;
  endtask

  // drive a read; data sampled before the capturing edge
  task automatic byte_rd(logic hi, logic with_tick, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr_hi = hi; tick = with_tick;
    #1 d = rdata;
    @(negedge clk); re = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 count", word_rdata, 16'h0000);
    check("R1 underflow", {15'b0, uf}, 16'h0000);
    byte_rd(1'b0, 1'b0, d);
    check("R10 lo after reset", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_byte_reload();
    byte_wr(1'b1, 8'h12);
    byte_wr(1'b0, 8'h34);
    check("R8 counter untouched by write", word_rdata, 16'h0000);
    cnt_en = 1'b1;
    pulse_start();
    check("R2 start loads reload", word_rdata, 16'h1234);
  endtask

  task automatic t_start_disabled();
    word_wr(16'hAAAA);
    check("R9 word write leaves counter", word_rdata, 16'h1234);
    cnt_en = 1'b0;
    pulse_start();
    check("R3 start ignored", word_rdata, 16'h1234);
    pulse_tick();
    check("R11 tick ignored while disabled", word_rdata, 16'h1234);
    cnt_en = 1'b1;
    pulse_tick();
    check("R11 tick ignored while not armed", word_rdata, 16'h1234);
    pulse_start();
    check("R9 word reload loaded", word_rdata, 16'hAAAA);
  endtask

  task automatic t_decrement();
    byte_wr(1'b0, 8'h55);
    for (int i = 0; i < 3; i++) pulse_tick();
    check("R4 three ticks", word_rdata, 16'hAAA7);
    pulse_start();
    check("R8 lo byte write only", word_rdata, 16'hAA55);
  endtask

  task automatic t_tear();
    logic [7:0] hi_b, lo_b;
    word_wr(16'h1200);
    pulse_start();
    byte_rd(1'b1, 1'b1, hi_b);
    check("R6 upper byte", {8'h0, hi_b}, 16'h0012);
    check("R4 live moved", word_rdata, 16'h11FF);
    byte_rd(1'b0, 1'b0, lo_b);
    check("R7 held lower byte", {8'h0, lo_b}, 16'h0000);
    byte_rd(1'b0, 1'b0, lo_b);
    check("R10 repeated lower read", {8'h0, lo_b}, 16'h0000);
  endtask

  task automatic t_underflow();
    word_wr(16'h0002);
    pulse_start();
    pulse_tick();
    pulse_tick();
    check("R4 reached zero", word_rdata, 16'h0000);
    check("R5 no early underflow", {15'b0, uf}, 16'h0000);
    pulse_tick();
    check("R5 reload on underflow", word_rdata, 16'h0002);
    check("R5 underflow high", {15'b0, uf}, 16'h0001);
    @(negedge clk);
    check("R5 underflow one cycle", {15'b0, uf}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_reload();
    t_start_disabled();
    t_decrement();
    t_tear();
    t_underflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule